// File: doc/BRIEF.md
# Accumulator Instruction Sequencer with Prioritised Interrupts

This block is the control sequencer and register file of a small stored-program machine. Program and data share one single-port memory. The machine has one working register, the accumulator (ACC). An index register (IX) sets the step between instruction addresses, and a status word holds the carry, overflow and interrupt-received flags. The sequencer walks each instruction through a fixed set of named states, drives the memory strobes, and looks for a pending interrupt only once an instruction has fully completed.

An instruction is a 16-bit word. Bits 15:12 hold the opcode and bits 11:0 hold a memory address. Interrupt request lines are latched into a pending set. At the end of each instruction the highest-priority pending source is taken: the program counter, ACC and the flags are copied to shadow registers, further interrupts are masked, and fetching resumes at that source's service address. A return instruction restores the shadow copies and removes the mask.

States and transitions:
- FADR → FRD → FCAP → IRLD → DEC.
- DEC goes to ORD for a load, ALU or index-load instruction. It goes to OWR for a store of ACC or of the status word. For every other opcode it goes to CHK.
- ORD → OCAP → EXE → CHK.
- OWR → CHK.
- CHK → FADR.

Top module: `acc_seq_core`

## Requirements
- R1: After reset, PC=0, IX=1, ACC=0, carry=overflow=0 and interrupts are enabled. The first memory read is therefore at address 0, and an immediate status store writes 0.
- R2: A fetch copies PC into the address register, reads memory with one cycle of latency into the data register, and then moves that word into the instruction register. PC becomes PC+IX during the read step. IX is loaded by LDX.
- R3: Opcodes are NOP=0, LDA=1, STA=2, ADD=3, SUB=4, AND=5, OR=6, XOR=7, JMP=8, LDX=9, STS=10 and RETI=15. Codes 11 to 14 act as NOP.
- R4: ADD and SUB write ACC op mem[addr] into ACC. For ADD, carry is the carry-out. For SUB, carry is not-borrow. For both, overflow flags a signed two's-complement overflow.
- R5: AND, OR and XOR write into ACC and clear both carry and overflow. LDA leaves the flags unchanged.
- R6: STS writes the status word: bit0 carry, bit1 overflow, bit2 interrupt-received (any request pending). All other bits are 0.
- R7: The read and write strobes are never active together. STA writes ACC.
- R8: Interrupts are taken only in the CHK state. The cycle of taking is marked by a one-cycle irq_taken pulse, which coincides with cycle_end.
- R9: Line 0 has the highest priority. Source i starts at VEC_BASE + i*VEC_STRIDE (0x40, 0x50, 0x60, 0x70 by default).
- R10: Entry saves PC, ACC and the flags, and masks interrupts. Requests that arrive while masked stay pending and are taken after the return.
- R11: RETI restores PC, ACC and the flags, re-enables interrupts, and the interrupted program resumes.
- R12: JMP loads PC with the operand address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NIRQ | Interrupt request lines, latched when high |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DW | Memory read data |
| cycle_end | output | 1 | High in the CHK state |
| irq_taken | output | 1 | High in the cycle an interrupt is entered |

## Verification
A wrong state or register value inside the sequencer shows up at the memory port within one instruction, which is at most nine cycles. Examples are a bad PC step, a wrong fetch address, a store of the wrong ACC value, or a wrong status word. Faults in saving or restoring context only become visible after the return: the main loop stores a corrupted ACC, or the service routines' stores appear in the wrong order. The bench therefore compares memory contents and the order of routine writes against values it computes itself.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int OPW = 4;

    typedef enum logic [3:0] {
        S_FADR, S_FRD, S_FCAP, S_IRLD, S_DEC,
        S_ORD, S_OCAP, S_EXE, S_OWR, S_CHK
    } state_t;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'd0,  OP_LDA = 4'd1, OP_STA = 4'd2, OP_ADD = 4'd3,
        OP_SUB  = 4'd4,  OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
        OP_JMP  = 4'd8,  OP_LDX = 4'd9, OP_STS = 4'd10, OP_RETI = 4'd15
    } opc_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  opc_t          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          c,
    output logic          v
);
    logic [DW:0] wide;

    always_comb begin
        wide = '0;
        res  = a;
        c    = 1'b0;
        v    = 1'b0;
        unique case (op)
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                res  = wide[DW-1:0];
                c    = wide[DW];
                v    = (a[DW-1] == b[DW-1]) && (res[DW-1] != a[DW-1]);
            end
            OP_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                res  = wide[DW-1:0];
                c    = ~wide[DW];
                v    = (a[DW-1] != b[DW-1]) && (res[DW-1] != a[DW-1]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_irq_pick.sv
module acc_irq_pick #(
    parameter int NIRQ       = 4,
    parameter int AW         = 12,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 'h10
) (
    input  logic [NIRQ-1:0] pend,
    output logic            any,
    output logic [NIRQ-1:0] grant,
    output logic [AW-1:0]   vec
);
    logic [NIRQ:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NIRQ; i++) begin : g_prio
        assign grant[i]  = pend[i] & ~seen[i];
        assign seen[i+1] = seen[i] | pend[i];
    end

    assign any = seen[NIRQ];

    always_comb begin
        vec = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (grant[i]) vec = AW'(VEC_BASE + i * VEC_STRIDE);
        end
    end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = AW + 4,
    parameter int NIRQ       = 4,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_req,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            cycle_end,
    output logic            irq_taken
);
    localparam int SRW = 3;

    state_t          st, st_nx;
    logic [AW-1:0]   pc, mar, pc_sh, ix;
    logic [DW-1:0]   mdr, cir, acc, acc_sh;
    logic            carry, ovf, c_sh, v_sh, ie;
    logic [NIRQ-1:0] pend, grant;
    logic            irq_any, take, sr_irq;
    logic [AW-1:0]   vec, operand;
    opc_t            op;
    logic [DW-1:0]   alu_res;
    logic            alu_c, alu_v;

    assign op      = opc_t'(cir[DW-1 -: OPW]);
    assign operand = cir[AW-1:0];
    assign sr_irq  = |pend;
    assign take    = (st == S_CHK) && ie && irq_any;

    acc_alu #(.DW(DW)) u_alu (
        .op(op), .a(acc), .b(mdr), .res(alu_res), .c(alu_c), .v(alu_v)
    );

    acc_irq_pick #(
        .NIRQ(NIRQ), .AW(AW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_pick (
        .pend(pend), .any(irq_any), .grant(grant), .vec(vec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_FADR;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = S_FADR;
        unique case (st)
            S_FADR: st_nx = S_FRD;
            S_FRD:  st_nx = S_FCAP;
            S_FCAP: st_nx = S_IRLD;
            S_IRLD: st_nx = S_DEC;
            S_DEC: begin
                unique case (op)
                    OP_LDA, OP_ADD, OP_SUB, OP_AND,
                    OP_OR, OP_XOR, OP_LDX:        st_nx = S_ORD;
                    OP_STA, OP_STS:               st_nx = S_OWR;
                    default:                      st_nx = S_CHK;
                endcase
            end
            S_ORD:  st_nx = S_OCAP;
            S_OCAP: st_nx = S_EXE;
            S_EXE:  st_nx = S_CHK;
            S_OWR:  st_nx = S_CHK;
            S_CHK:  st_nx = S_FADR;
            default: st_nx = S_FADR;
        endcase
    end

    // register set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; mar <= '0; ix <= AW'(1);
            mdr <= '0; cir <= '0; acc <= '0;
            carry <= 1'b0; ovf <= 1'b0; ie <= 1'b1;
            pend <= '0; pc_sh <= '0; acc_sh <= '0;
            c_sh <= 1'b0; v_sh <= 1'b0;
        end else begin
            pend <= (pend & ~(take ? grant : '0)) | irq_req;
            case (st)
                S_FADR: mar <= pc;
                S_FRD:  pc  <= pc + ix;
                S_FCAP: mdr <= mem_rdata;
                S_IRLD: cir <= mdr;
                S_DEC: begin
                    mar <= operand;
                    if (op == OP_JMP) pc <= operand;
                    if (op == OP_RETI) begin
                        pc    <= pc_sh;
                        acc   <= acc_sh;
                        carry <= c_sh;
                        ovf   <= v_sh;
                        ie    <= 1'b1;
                    end
                end
                S_OCAP: mdr <= mem_rdata;
                S_EXE: begin
                    case (op)
                        OP_LDA: acc <= mdr;
                        OP_LDX: ix  <= mdr[AW-1:0];
                        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
                            acc   <= alu_res;
                            carry <= alu_c;
                            ovf   <= alu_v;
                        end
                        default: ;
                    endcase
                end
                S_CHK: begin
                    if (take) begin
                        pc_sh  <= pc;
                        acc_sh <= acc;
                        c_sh   <= carry;
                        v_sh   <= ovf;
                        pc     <= vec;
                        ie     <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr  = mar;
        mem_wdata = (op == OP_STS) ? {{(DW-SRW){1'b0}}, sr_irq, ovf, carry} : acc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        cycle_end = 1'b0;
        irq_taken = 1'b0;
        unique case (st)
            S_FRD, S_ORD: mem_rd = 1'b1;
            S_OWR:        mem_wr = 1'b1;
            S_CHK: begin
                cycle_end = 1'b1;
                irq_taken = take;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
    import acc_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input state_t        st,
    input opc_t          op,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] ix,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] acc_sh,
    input logic          ie,
    input logic          carry,
    input logic          ovf,
    input logic          irq_taken,
    input logic          mem_rd,
    input logic          mem_wr
);
    a_r7_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FRD) |=> (pc == AW'($past(pc) + $past(ix))));

    a_r10_mask_entry: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !ie);

    a_r10_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq_taken);

    a_r11_reti_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DEC && op == OP_RETI) |=> (acc == $past(acc_sh) && ie));

    a_r5_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXE && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> (!carry && !ovf));
endmodule

bind acc_seq_core acc_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .op(op), .pc(pc), .ix(ix),
    .acc(acc), .acc_sh(acc_sh), .ie(ie), .carry(carry), .ovf(ovf),
    .irq_taken(irq_taken), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/test_acc_seq_core.sv
module test_acc_seq_core;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int NIRQ = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq_req = '0;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata, mem_rdata;
    logic            mem_rd, mem_wr, cycle_end, irq_taken;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [15:0] mem [256];
    logic [3:0]  wlog [16];
    int          wcnt;
    int          tcnt;
    int          bad_take;

    always #10 clk = ~clk;

    acc_seq_core #(.AW(AW), .DW(DW), .NIRQ(NIRQ)) i_acc_seq_core (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata),
        .cycle_end(cycle_end), .irq_taken(irq_taken)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0; tcnt <= 0; bad_take <= 0;
        end else begin
            if (mem_wr && mem_addr[7:4] == 4'hA) begin
                wlog[wcnt[3:0]] <= mem_addr[3:0];
                wcnt <= wcnt + 1;
            end
            if (irq_taken) tcnt <= tcnt + 1;
            if (irq_taken && !cycle_end) bad_take <= bad_take + 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    // returns {carry, overflow, result}
    function automatic logic [17:0] ref_alu(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] w;
        logic [15:0] r;
        logic c, v;
        c = 1'b0; v = 1'b0; r = a;
        case (op)
            4'd3: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16];
                        v = (a[15] == b[15]) && (r[15] != a[15]); end
            4'd4: begin r = a - b; c = (a >= b);
                        v = (a[15] != b[15]) && (r[15] != a[15]); end
            4'd5: r = a & b;
            4'd6: r = a | b;
            4'd7: r = a ^ b;
            default: r = a;
        endcase
        return {c, v, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        irq_req = '0;
        clear_mem();
    endtask

    task automatic release_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [3:0]  op;
        logic [15:0] a, b;
        logic [17:0] e;
        logic [3:0]  ops [5];
        logic [15:0] da [6];
        logic [15:0] db [6];
        logic [3:0]  dop [6];
        ops[0] = 4'd3; ops[1] = 4'd4; ops[2] = 4'd5; ops[3] = 4'd6; ops[4] = 4'd7;
        dop[0] = 4'd3; da[0] = 16'h7FFF; db[0] = 16'h0001;
        dop[1] = 4'd3; da[1] = 16'hFFFF; db[1] = 16'h0001;
        dop[2] = 4'd4; da[2] = 16'h0005; db[2] = 16'h0007;
        dop[3] = 4'd4; da[3] = 16'h8000; db[3] = 16'h0001;
        dop[4] = 4'd4; da[4] = 16'h0009; db[4] = 16'h0009;
        dop[5] = 4'd7; da[5] = 16'hF0F0; db[5] = 16'h0FF0;
        void'($urandom(32'd20240611));

        // R1 / R12 reset state and jump
        hold_reset();
        mem[0] = enc(4'd10, 12'h091);
        mem[1] = enc(4'd2, 12'h090);
        mem[2] = enc(4'd8, 12'h004);
        mem[3] = enc(4'd2, 12'h092);
        mem[4] = enc(4'd2, 12'h093);
        mem[5] = enc(4'd8, 12'h005);
        mem[8'h90] = 16'hBEEF; mem[8'h91] = 16'hBEEF;
        mem[8'h92] = 16'hDEAD; mem[8'h93] = 16'hBEEF;
        release_reset();
        while (!mem_rd) @(negedge clk);
        check("R1 first fetch address", 32'(mem_addr), 32'h0);
        wait_cycles(60);
        check("R1 status after reset", 32'(mem[8'h91]), 32'h0);
        check("R1 ACC after reset", 32'(mem[8'h90]), 32'h0);
        check("R12 jump skips address 3", 32'(mem[8'h92]), 32'hDEAD);
        check("R12 jump target executed", 32'(mem[8'h93]), 32'h0);

        // R2 PC advances by IX
        hold_reset();
        mem[0] = enc(4'd9, 12'h080);
        mem[1] = enc(4'd1, 12'h081);
        mem[2] = enc(4'd2, 12'h092);
        mem[3] = enc(4'd2, 12'h090);
        mem[4] = enc(4'd2, 12'h092);
        mem[5] = enc(4'd2, 12'h093);
        mem[6] = enc(4'd2, 12'h092);
        mem[7] = enc(4'd8, 12'h007);
        mem[8'h80] = 16'h0002; mem[8'h81] = 16'h1234;
        mem[8'h92] = 16'hDEAD;
        release_reset();
        wait_cycles(80);
        check("R2 stride step 1->3", 32'(mem[8'h90]), 32'h1234);
        check("R2 stride step 3->5", 32'(mem[8'h93]), 32'h1234);
        check("R2 even addresses skipped", 32'(mem[8'h92]), 32'hDEAD);

        // R3 R4 R5 R6 arithmetic/logic, directed then random
        for (int it = 0; it < 40; it++) begin
            if (it < 6) begin
                op = dop[it]; a = da[it]; b = db[it];
            end else begin
                op = ops[$urandom % 5]; a = 16'($urandom); b = 16'($urandom);
            end
            hold_reset();
            mem[0] = enc(4'd1, 12'h080);
            mem[1] = enc(op, 12'h081);
            mem[2] = enc(4'd2, 12'h090);
            mem[3] = enc(4'd10, 12'h091);
            mem[4] = enc(4'd8, 12'h004);
            mem[8'h80] = a; mem[8'h81] = b;
            release_reset();
            wait_cycles(70);
            e = ref_alu(op, a, b);
            if (op == 4'd3 || op == 4'd4) begin
                check("R4 arith result", 32'(mem[8'h90]), 32'(e[15:0]));
                check("R4 R6 arith flags", 32'(mem[8'h91]), 32'({e[16], e[17]}));
            end else begin
                check("R5 logic result", 32'(mem[8'h90]), 32'(e[15:0]));
                check("R5 R6 logic flags clear", 32'(mem[8'h91]), 32'h0);
            end
        end

        // R8 R9 R10 R11 interrupts
        hold_reset();
        mem[0] = enc(4'd1, 12'h080);
        mem[1] = enc(4'd3, 12'h081);
        mem[2] = enc(4'd2, 12'h090);
        mem[3] = enc(4'd8, 12'h002);
        mem[8'h40] = enc(4'd1, 12'h083);
        mem[8'h41] = enc(4'd2, 12'h0A0);
        mem[8'h42] = enc(4'd15, 12'h000);
        mem[8'h50] = enc(4'd1, 12'h082);
        mem[8'h51] = enc(4'd2, 12'h0A1);
        mem[8'h52] = enc(4'd10, 12'h0B1);
        mem[8'h53] = enc(4'd15, 12'h000);
        mem[8'h60] = enc(4'd1, 12'h084);
        mem[8'h61] = enc(4'd2, 12'h0A2);
        mem[8'h62] = enc(4'd15, 12'h000);
        mem[8'h80] = 16'h0005; mem[8'h81] = 16'h0003;
        mem[8'h82] = 16'h1111; mem[8'h83] = 16'h2222; mem[8'h84] = 16'h3333;
        release_reset();
        wait_cycles(60);
        irq_req = 4'b0110;
        @(negedge clk);
        irq_req = 4'b0000;
        while (!irq_taken) @(negedge clk);
        wait_cycles(5);
        irq_req = 4'b0001;
        @(negedge clk);
        irq_req = 4'b0000;
        wait_cycles(300);
        check("R8 R10 three entries", 32'(tcnt), 32'd3);
        check("R8 taken only at cycle end", 32'(bad_take), 32'd0);
        check("R9 first routine line1", 32'(wlog[0]), 32'h1);
        check("R10 masked line0 waits", 32'(wlog[1]), 32'h0);
        check("R9 lowest last", 32'(wlog[2]), 32'h2);
        check("R10 R6 pending bit in status", 32'(mem[8'hB1]), 32'h4);
        check("R11 ACC restored on resume", 32'(mem[8'h90]), 32'h0008);
        check("R9 routine data", 32'(mem[8'hA1]), 32'h1111);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule